// File: doc/BRIEF.md
# Infrared Command Transmit Sequencer

This block decides when an infrared command goes out and in what bit order. Software loads the command as 16-bit words into a code buffer. An optional alternative repeat command goes into a second buffer. Raising `start` launches the command. Each bit is handed to a downstream symbol modulator as a one-cycle `sym_valid` pulse. The sequencer then waits for that modulator's `symbol_done` before it presents the next bit. Words go out in write order, least-significant bit first.

Reading a buffer does not consume its words. A replay pointer rewinds at every command launch, so the stored command can be sent any number of times.

A repeat timer is reloaded at each launch and counts carrier ticks. When it expires, the next command follows. The next command is either the code buffer again or the repeat buffer, chosen by `repeat_sel`. If the expiry falls while a command is still going out, the repeat begins as soon as that command ends. Dropping `start` aborts the transmission and empties the code buffer. Completion of each command can raise a maskable interrupt, which clears when its status is read.

Top module: `ir_tx_sequencer`

## Requirements
- R1: While `enable` is 0, the block stays in its reset state. `busy`, `irq` and `sym_valid` are 0, and both word counts are 0 one cycle after `enable` is seen low.
- R2: Each write strobe adds one to that buffer's word count, up to DEPTH. Writes to a full buffer are dropped. Sending a command never changes a count.
- R3: A one-cycle `code_flush` sets the code count to 0, and a one-cycle `rep_flush` sets the repeat count to 0. Neither flush touches the other buffer's count.
- R4: On a rising `start` with a non-empty code buffer, `busy` goes to 1. Every stored bit appears on `sym_bit` with a one-cycle `sym_valid` pulse. Bit 0 of word 0 goes first, and each word goes out in ascending bit order. The next bit is presented in the cycle after `symbol_done` is sampled.
- R5: After the last bit's `symbol_done`, `busy` returns to 0. If `irq_en` is 1, `irq` goes to 1 at that point; if `irq_en` is 0, `irq` stays at 0.
- R6: A pulse on `irq_ack` while no command is finishing clears `irq` on the next cycle.
- R7: With a non-zero `repeat_period` P, a new command starts P carrier ticks after the previous launch. The new command resends the code buffer when `repeat_sel` is 0, and sends the repeat buffer when `repeat_sel` is 1.
- R8: If the repeat timer expires during a transmission, the repeat's first bit is presented one cycle after the final bit of that transmission would otherwise have been followed by idle. With the modulator model in use, the spacing is one cycle more than the normal bit-to-bit spacing.
- R9: Dropping `start` from 1 to 0 stops transmission (`busy` 0 next cycle). It empties the code buffer (count 0), cancels pending repeats, and leaves the repeat buffer's count unchanged.
- R10: When `repeat_period` is 0, a command is sent exactly once per rising `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; 0 holds everything in reset |
| start | input | 1 | Rising edge launches; falling edge aborts and empties the code buffer |
| repeat_sel | input | 1 | Repeat content: 0 = code buffer, 1 = repeat buffer |
| irq_en | input | 1 | Allows completion to raise `irq` |
| code_flush | input | 1 | Empties the code buffer |
| rep_flush | input | 1 | Empties the repeat buffer |
| code_wr | input | 1 | Writes `wr_data` into the code buffer |
| rep_wr | input | 1 | Writes `wr_data` into the repeat buffer |
| wr_data | input | WW | Word to write |
| repeat_period | input | TW | Repeat interval in carrier ticks, 0 = no repeat |
| carrier_tick | input | 1 | One pulse per carrier period |
| irq_ack | input | 1 | Interrupt status read strobe |
| symbol_done | input | 1 | Modulator has finished the current bit |
| sym_valid | output | 1 | One-cycle pulse presenting a bit |
| sym_bit | output | 1 | Bit to modulate |
| busy | output | 1 | A command is being sent |
| code_count | output | CW | Words in the code buffer |
| rep_count | output | CW | Words in the repeat buffer |
| irq | output | 1 | Completion interrupt |

## Verification
The command is tried with two code words whose bit patterns differ across the whole word. That separates least-significant-first order from most-significant-first order, and word order from reversed order. It is also tried against a repeat buffer holding different words, so the resent content shows which buffer the repeat came from.

Two repeat periods are swept, each with both `repeat_sel` values. A long period exposes the timer measured from launch (R7). A short period expires mid-command and exposes the one-cycle idle gap (R8).

A zero period checks for single-shot operation. Overfilling the buffers, flushing each buffer separately, and stopping mid-command all show which count moves and which count stays put.

// File: rtl/ir_tx_sequencer.sv
module ir_tx_sequencer #(
  parameter int DEPTH = 8,
  parameter int WW    = 16,
  parameter int TW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int BW   = $clog2(WW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          start,
  input  logic          repeat_sel,
  input  logic          irq_en,
  input  logic          code_flush,
  input  logic          rep_flush,
  input  logic          code_wr,
  input  logic          rep_wr,
  input  logic [WW-1:0] wr_data,
  input  logic [TW-1:0] repeat_period,
  input  logic          carrier_tick,
  input  logic          irq_ack,
  input  logic          symbol_done,
  output logic          sym_valid,
  output logic          sym_bit,
  output logic          busy,
  output logic [CW-1:0] code_count,
  output logic [CW-1:0] rep_count,
  output logic          irq
);
  typedef enum logic [1:0] {IDLE, EMIT, HOLD} st_t;

  logic [WW-1:0] cmem [DEPTH];
  logic [WW-1:0] rmem [DEPTH];
  logic [CW-1:0] ccnt, rcnt;
  st_t           st;
  logic          src, start_q, rep_pend, tmr_run;
  logic [AW-1:0] widx;
  logic [BW-1:0] bidx;
  logic [TW-1:0] tmr;

  wire stop        = start_q & ~start;
  wire start_rise  = start & ~start_q;
  wire idle        = (st == IDLE);
  wire rep_has     = repeat_sel ? (rcnt != '0) : (ccnt != '0);
  wire launch_new  = idle & start_rise & (ccnt != '0);
  wire launch_rep  = idle & rep_pend & start & rep_has;
  wire launch      = launch_new | launch_rep;
  wire [CW-1:0] scnt = src ? rcnt : ccnt;
  wire last_bit    = (bidx == BW'(WW-1));
  wire last_word   = ({1'b0, widx} == scnt - CW'(1));
  wire bit_done    = (st == HOLD) & symbol_done & ~stop;
  wire cmd_done    = bit_done & last_bit & last_word;
  wire [WW-1:0] cur = src ? rmem[widx] : cmem[widx];

  assign sym_valid  = (st == EMIT);
  assign sym_bit    = cur[bidx];
  assign busy       = ~idle;
  assign code_count = ccnt;
  assign rep_count  = rcnt;

  always_ff @(posedge clk) begin
    if (enable && code_wr && ccnt != CW'(DEPTH)) cmem[ccnt[AW-1:0]] <= wr_data;
    if (enable && rep_wr && rcnt != CW'(DEPTH))  rmem[rcnt[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccnt <= '0;
      rcnt <= '0;
    end else begin
      if (!enable || code_flush || stop) ccnt <= '0;
      else if (code_wr && ccnt != CW'(DEPTH)) ccnt <= ccnt + CW'(1);
      if (!enable || rep_flush) rcnt <= '0;
      else if (rep_wr && rcnt != CW'(DEPTH)) rcnt <= rcnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; src <= 1'b0; start_q <= 1'b0; rep_pend <= 1'b0;
      tmr_run <= 1'b0; tmr <= '0; widx <= '0; bidx <= '0;
    end else if (!enable) begin
      st <= IDLE; src <= 1'b0; start_q <= 1'b0; rep_pend <= 1'b0;
      tmr_run <= 1'b0; tmr <= '0; widx <= '0; bidx <= '0;
    end else begin
      start_q <= start;
      if (stop) begin
        st <= IDLE; rep_pend <= 1'b0; tmr_run <= 1'b0;
      end else begin
        case (st)
          IDLE: begin
            if (launch) begin
              st <= EMIT; src <= launch_rep & repeat_sel;
              widx <= '0; bidx <= '0; rep_pend <= 1'b0;
            end else if (rep_pend) rep_pend <= 1'b0;
          end
          EMIT: st <= HOLD;
          HOLD: if (symbol_done) begin
            if (!last_bit) begin
              bidx <= bidx + BW'(1); st <= EMIT;
            end else begin
              bidx <= '0;
              if (last_word) st <= IDLE;
              else begin
                widx <= widx + AW'(1); st <= EMIT;
              end
            end
          end
          default: st <= IDLE;
        endcase
        if (launch) begin
          tmr <= repeat_period; tmr_run <= (repeat_period != '0);
        end else if (tmr_run && carrier_tick) begin
          if (tmr == TW'(1)) begin
            tmr_run <= 1'b0; rep_pend <= 1'b1;
          end else tmr <= tmr - TW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else if (!enable) irq <= 1'b0;
    else if (cmd_done && irq_en) irq <= 1'b1;
    else if (irq_ack) irq <= 1'b0;
  end
endmodule

// File: rtl/ir_tx_sequencer_chk.sv
module ir_tx_sequencer_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          start,
  input logic          irq_ack,
  input logic          sym_valid,
  input logic          busy,
  input logic [CW-1:0] code_count,
  input logic [CW-1:0] rep_count,
  input logic          irq
);
  // R1
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !irq && code_count == '0 && rep_count == '0));
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_count <= CW'(DEPTH)) && (rep_count <= CW'(DEPTH)));
  // R4
  bit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> (busy ##1 !sym_valid));
  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !busy) |=> !irq);
  // R9
  stop_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !start && $past(start)) |=> (!busy && code_count == '0));
endmodule

bind ir_tx_sequencer ir_tx_sequencer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .irq_ack(irq_ack),
  .sym_valid(sym_valid), .busy(busy), .code_count(code_count),
  .rep_count(rep_count), .irq(irq)
);

// File: tb/ir_tx_sequencer_tb.sv
`timescale 1ns/1ps
module ir_tx_sequencer_tb;
  localparam int DEPTH = 4;
  localparam int CW = 3;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, start = 1'b0, repeat_sel = 1'b0;
  logic irq_en = 1'b0, code_flush = 1'b0, rep_flush = 1'b0, code_wr = 1'b0, rep_wr = 1'b0;
  logic [15:0] wr_data = '0, repeat_period = '0;
  logic carrier_tick = 1'b0, irq_ack = 1'b0, symbol_done = 1'b0;
  logic sym_valid, sym_bit, busy, irq;
  logic [CW-1:0] code_count, rep_count;

  ir_tx_sequencer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .repeat_sel(repeat_sel),
    .irq_en(irq_en), .code_flush(code_flush), .rep_flush(rep_flush), .code_wr(code_wr),
    .rep_wr(rep_wr), .wr_data(wr_data), .repeat_period(repeat_period),
    .carrier_tick(carrier_tick), .irq_ack(irq_ack), .symbol_done(symbol_done),
    .sym_valid(sym_valid), .sym_bit(sym_bit), .busy(busy), .code_count(code_count),
    .rep_count(rep_count), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int cyc = 0, ntest = 0, nfail = 0, nrx = 0, dly = 0;
  logic rxb [0:255];
  int stamp [0:255];
  logic [15:0] cw [0:1];
  logic [15:0] rw [0:1];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    carrier_tick = (cyc % 4 == 0);
    symbol_done = 1'b0;
    if (sym_valid) begin
      if (nrx < 256) begin rxb[nrx] = sym_bit; stamp[nrx] = cyc; end
      nrx++;
      dly = 3;
    end else if (dly != 0) begin
      dly--;
      if (dly == 1) symbol_done = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit rep, input logic [15:0] d);
    @(negedge clk);
    wr_data = d; code_wr = ~rep; rep_wr = rep;
    @(negedge clk);
    code_wr = 1'b0; rep_wr = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic wait_bits(input int n);
    int t = 0;
    while (nrx < n && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic load_code();
    wr(1'b0, cw[0]); wr(1'b0, cw[1]);
  endtask

  function automatic logic exp_bit(input bit rep, input int k);
    logic [15:0] w;
    w = rep ? rw[k/16] : cw[k/16];
    return w[k%16];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    cw[0] = 16'hA5C3; cw[1] = 16'h1234;
    rw[0] = 16'h00FF; rw[1] = 16'h8001;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !irq && !sym_valid, "R1 reset outputs", int'(busy), 0);
    chk(code_count == 0 && rep_count == 0, "R1 reset counts", int'(code_count), 0);
    enable = 1'b1;
    load_code();
    chk(code_count == 2, "R2 code count", int'(code_count), 2);

    // single shot, R4 R5 R10
    irq_en = 1'b1; repeat_period = '0; nrx = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(busy == 1'b1, "R4 busy during send", int'(busy), 1);
    wait_bits(32);
    while (busy) @(negedge clk);
    chk(nrx == 32, "R4 bit count", nrx, 32);
    begin
      int bad = 0, gap = 0;
      for (int k = 0; k < 32; k++) if (rxb[k] !== exp_bit(1'b0, k)) bad++;
      for (int k = 1; k < 32; k++) if (stamp[k] - stamp[k-1] != 3) gap++;
      chk(bad == 0, "R4 bit order", bad, 0);
      chk(gap == 0, "R4 bit spacing", gap, 0);
    end
    chk(irq == 1'b1, "R5 irq on completion", int'(irq), 1);
    chk(code_count == 2, "R2 count kept by replay", int'(code_count), 2);
    repeat (200) @(negedge clk);
    chk(nrx == 32, "R10 no repeat at zero period", nrx, 32);
    pulse_ack();
    chk(irq == 1'b0, "R6 irq cleared by ack", int'(irq), 0);

    start = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(code_count == 0, "R9 stop empties code", int'(code_count), 0);

    // R2 saturation, R3 separate flushes
    load_code();
    for (int i = 0; i < 5; i++) wr(1'b1, 16'h7000 + 16'(i));
    chk(rep_count == 4, "R2 saturate at depth", int'(rep_count), 4);
    @(negedge clk); code_flush = 1'b1; @(negedge clk); code_flush = 1'b0;
    chk(code_count == 0, "R3 code flush", int'(code_count), 0);
    chk(rep_count == 4, "R3 code flush keeps repeat", int'(rep_count), 4);
    @(negedge clk); rep_flush = 1'b1; @(negedge clk); rep_flush = 1'b0;
    chk(rep_count == 0, "R3 repeat flush", int'(rep_count), 0);
    load_code();
    wr(1'b1, rw[0]); wr(1'b1, rw[1]);

    // repeat sweep, R5 R7 R8 R9
    for (int sel = 0; sel < 2; sel++) begin
      for (int pi = 0; pi < 2; pi++) begin
        int p, bad, d1, d2, held;
        p = (pi == 0) ? 60 : 10;
        repeat_sel = sel[0]; irq_en = (sel == 0); repeat_period = 16'(p); nrx = 0;
        @(negedge clk); start = 1'b1;
        wait_bits(96);
        start = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(!busy, "R9 stop clears busy", int'(busy), 0);
        chk(code_count == 0, "R9 stop empties code", int'(code_count), 0);
        chk(rep_count == 2, "R9 repeat buffer kept", int'(rep_count), 2);
        held = nrx;
        repeat (300) @(negedge clk);
        chk(nrx == held, "R9 no bits after stop", nrx, held);
        bad = 0;
        for (int k = 0; k < 32; k++) if (rxb[k] !== exp_bit(1'b0, k)) bad++;
        for (int k = 0; k < 64; k++) if (rxb[32+k] !== exp_bit(sel[0], k % 32)) bad++;
        chk(bad == 0, sel ? "R7 repeat buffer content" : "R7 code resent", bad, 0);
        if (p == 60) begin
          d1 = stamp[32] - stamp[0]; d2 = stamp[64] - stamp[32];
          chk(d1 >= 4*p-3 && d1 <= 4*p+1, "R7 repeat interval 1", d1, 4*p);
          chk(d2 >= 4*p-3 && d2 <= 4*p+1, "R7 repeat interval 2", d2, 4*p);
        end else begin
          chk(stamp[32] - stamp[31] == 4, "R8 immediate repeat", stamp[32] - stamp[31], 4);
          chk(stamp[64] - stamp[63] == 4, "R8 immediate repeat 2", stamp[64] - stamp[63], 4);
        end
        chk(irq == (sel == 0), "R5 irq follows irq_en", int'(irq), int'(sel == 0));
        pulse_ack();
        load_code();
      end
    end

    // R1 disable clears
    irq_en = 1'b1; repeat_period = '0; nrx = 0;
    @(negedge clk); start = 1'b1;
    wait_bits(5);
    enable = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(!busy && !sym_valid, "R1 disable stops", int'(busy), 0);
    chk(code_count == 0 && rep_count == 0, "R1 disable clears counts", int'(rep_count), 0);
    chk(!irq, "R1 disable clears irq", int'(irq), 0);

    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule